// File: doc/BRIEF.md
# Unified Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit load/store instruction word into every control line the single-cycle datapath needs. A conventional design splits this work between a main decoder and a second decoder that picks the arithmetic operation. Here both jobs sit in one module. The function field is examined in the same place as the opcode, so register-form instructions get their arithmetic code directly. Two extra controls are produced as well: one picks zero or sign extension of the 16-bit immediate, and one steers the next program counter from a register.

The decoder has no state. Every output depends only on the two input fields presented in the same cycle, and it settles before the datapath clock edge that uses it. An encoding the decoder does not recognise leaves every write enable and every program-counter redirect low. This lets a stray word pass through the pipeline slot without changing architectural state.

Top module: `ctl_decoder_unified`

## Requirements
- R1: `alu_op` encodes add=00, xor=01, sub=10, slt=11. Add is used for load (opcode 100011), store (101011), add-immediate (001000), register jump (opcode 000000, funct 001000) and register add (funct 100000). Xor is used for xor-immediate (001110). Sub is used for branch-not-equal (000101) and register subtract (funct 100010). Slt is used for set-less-than (funct 101010). Jump (000010) and unrecognised encodings give 00.
- R2: `mem_wr_en` is 1 only for store, and `mem_to_reg` is 1 only for load.
- R3: `reg_wr_en` is 1 for load, xor-immediate, add-immediate, register add, register subtract and set-less-than. It is 0 for every other encoding.
- R4: `reg_dst_rd` is 1 only for register add, register subtract and set-less-than. It is 0 for every other encoding, including the immediate-form writes.
- R5: `alu_src_imm` is 1 for load, store, xor-immediate and add-immediate. It is 0 otherwise.
- R6: `imm_sign_ext` is 0 only for xor-immediate. It is 1 for every other encoding.
- R7: `pc_jump` is 1 only for jump, `pc_jump_reg` is 1 only for register jump, and `pc_branch_ne` is 1 only for branch-not-equal. At most one of the three is high.
- R8: An unrecognised opcode, or opcode 000000 with an unrecognised funct, drives `reg_wr_en`, `mem_wr_en`, `mem_to_reg`, `pc_jump`, `pc_jump_reg` and `pc_branch_ne` low.
- R9: For any non-zero recognised opcode the funct value has no effect on any output.
- R10: The outputs are a pure function of the present inputs, with no clock and no retained state. The result of one encoding does not depend on the encoding applied before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_opcode | input | 6 | Opcode field, bits 31..26 of the instruction |
| instr_funct | input | 6 | Function field, bits 5..0 of the instruction |
| reg_dst_rd | output | 1 | Write-register select: 1 = rd field, 0 = rt field |
| mem_to_reg | output | 1 | Write-back select: 1 = memory read data |
| alu_op | output | 2 | Arithmetic operation code |
| mem_wr_en | output | 1 | Data memory write enable |
| alu_src_imm | output | 1 | Second operand select: 1 = extended immediate |
| reg_wr_en | output | 1 | Register file write enable |
| imm_sign_ext | output | 1 | Immediate extension: 1 = sign, 0 = zero |
| pc_jump | output | 1 | Next PC from the absolute jump target |
| pc_jump_reg | output | 1 | Next PC from a register |
| pc_branch_ne | output | 1 | Conditional branch on inequality |

## Verification
The decoder holds no state, so a wrong internal decision shows up only as a wrong output level. It appears half a cycle after the offending encoding is applied, and it disappears when the next encoding arrives. For that reason every encoding is compared field by field at once. A fault in the shared field matcher would misroute a whole class of instructions. A fault in the final signal table would corrupt one field of one class. The sweeps over all 64 opcodes and all 64 funct values under opcode zero expose both kinds. The sweep of funct under non-zero opcodes catches a matcher that lets the function field leak into I-form and J-form decoding.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int N_OPC   = 7;
  localparam int N_FN    = 4;

  // opcode table, index 0 at the least significant slot
  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

  localparam logic [FN_W-1:0] FN_JREG = 6'b001000;
  localparam logic [FN_W-1:0] FN_ADD  = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB  = 6'b100010;
  localparam logic [FN_W-1:0] FN_SLT  = 6'b101010;

  localparam logic [N_OPC*OPC_W-1:0] OPC_TABLE =
    {OPC_JMP, OPC_ADDI, OPC_XORI, OPC_BNE, OPC_STORE, OPC_LOAD, OPC_REG};
  localparam logic [N_FN*FN_W-1:0] FN_TABLE =
    {FN_SLT, FN_SUB, FN_ADD, FN_JREG};

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_XOR = 2'b01,
    ALU_SUB = 2'b10,
    ALU_SLT = 2'b11
  } alu_op_e;

  typedef enum logic [3:0] {
    K_NONE, K_LOAD, K_STORE, K_BNE, K_XORI, K_ADDI,
    K_JMP, K_JREG, K_ADD, K_SUB, K_SLT
  } insn_kind_e;

  typedef struct packed {
    logic    reg_dst_rd;
    logic    mem_to_reg;
    alu_op_e alu_op;
    logic    mem_wr_en;
    logic    alu_src_imm;
    logic    reg_wr_en;
    logic    imm_sign_ext;
    logic    pc_jump;
    logic    pc_jump_reg;
    logic    pc_branch_ne;
  } ctl_bundle_t;

endpackage

// File: rtl/ctl_field_match.sv
// Parallel equality compare of one field against a table of patterns.
module ctl_field_match #(
  parameter int                   FIELD_W = 6,
  parameter int                   N_PAT   = 4,
  parameter logic [N_PAT*FIELD_W-1:0] PATTERNS = '0
) (
  input  logic [FIELD_W-1:0] field,
  output logic [N_PAT-1:0]   hit
);

  for (genvar i = 0; i < N_PAT; i++) begin : g_cmp
    assign hit[i] = (field == PATTERNS[i*FIELD_W +: FIELD_W]);
  end

endmodule

// File: rtl/ctl_kind_select.sv
// Folds the opcode and funct match vectors into one instruction class.
module ctl_kind_select
  import ctl_dec_pkg::*;
#(
  parameter int N_O = N_OPC,
  parameter int N_F = N_FN
) (
  input  logic [N_O-1:0] op_hit,
  input  logic [N_F-1:0] fn_hit,
  output insn_kind_e     kind
);

  always_comb begin
    kind = K_NONE;
    if (op_hit[0]) begin
      if      (fn_hit[0]) kind = K_JREG;
      else if (fn_hit[1]) kind = K_ADD;
      else if (fn_hit[2]) kind = K_SUB;
      else if (fn_hit[3]) kind = K_SLT;
    end
    else if (op_hit[1]) kind = K_LOAD;
    else if (op_hit[2]) kind = K_STORE;
    else if (op_hit[3]) kind = K_BNE;
    else if (op_hit[4]) kind = K_XORI;
    else if (op_hit[5]) kind = K_ADDI;
    else if (op_hit[6]) kind = K_JMP;
  end

endmodule

// File: rtl/ctl_signal_gen.sv
// Maps an instruction class onto the full control bundle.
module ctl_signal_gen
  import ctl_dec_pkg::*;
(
  input  insn_kind_e  kind,
  output ctl_bundle_t ctl
);

  always_comb begin
    ctl              = '0;
    ctl.alu_op       = ALU_ADD;
    ctl.imm_sign_ext = 1'b1;
    case (kind)
      K_LOAD: begin
        ctl.mem_to_reg  = 1'b1;
        ctl.alu_src_imm = 1'b1;
        ctl.reg_wr_en   = 1'b1;
      end
      K_STORE: begin
        ctl.mem_wr_en   = 1'b1;
        ctl.alu_src_imm = 1'b1;
      end
      K_BNE: begin
        ctl.alu_op       = ALU_SUB;
        ctl.pc_branch_ne = 1'b1;
      end
      K_XORI: begin
        ctl.alu_op       = ALU_XOR;
        ctl.alu_src_imm  = 1'b1;
        ctl.reg_wr_en    = 1'b1;
        ctl.imm_sign_ext = 1'b0;
      end
      K_ADDI: begin
        ctl.alu_src_imm = 1'b1;
        ctl.reg_wr_en   = 1'b1;
      end
      K_JMP:  ctl.pc_jump     = 1'b1;
      K_JREG: ctl.pc_jump_reg = 1'b1;
      K_ADD: begin
        ctl.reg_dst_rd = 1'b1;
        ctl.reg_wr_en  = 1'b1;
      end
      K_SUB: begin
        ctl.reg_dst_rd = 1'b1;
        ctl.reg_wr_en  = 1'b1;
        ctl.alu_op     = ALU_SUB;
      end
      K_SLT: begin
        ctl.reg_dst_rd = 1'b1;
        ctl.reg_wr_en  = 1'b1;
        ctl.alu_op     = ALU_SLT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctl_decoder_unified.sv
module ctl_decoder_unified
  import ctl_dec_pkg::*;
#(
  parameter int OP_W  = OPC_W,
  parameter int FUN_W = FN_W
) (
  input  logic [OP_W-1:0]  instr_opcode,
  input  logic [FUN_W-1:0] instr_funct,
  output logic             reg_dst_rd,
  output logic             mem_to_reg,
  output logic [1:0]       alu_op,
  output logic             mem_wr_en,
  output logic             alu_src_imm,
  output logic             reg_wr_en,
  output logic             imm_sign_ext,
  output logic             pc_jump,
  output logic             pc_jump_reg,
  output logic             pc_branch_ne
);

  logic [N_OPC-1:0] op_hit;
  logic [N_FN-1:0]  fn_hit;
  insn_kind_e       kind;
  ctl_bundle_t      ctl;

  ctl_field_match #(.FIELD_W(OP_W), .N_PAT(N_OPC), .PATTERNS(OPC_TABLE)) u_op_match (
    .field (instr_opcode),
    .hit   (op_hit)
  );

  ctl_field_match #(.FIELD_W(FUN_W), .N_PAT(N_FN), .PATTERNS(FN_TABLE)) u_fn_match (
    .field (instr_funct),
    .hit   (fn_hit)
  );

  ctl_kind_select #(.N_O(N_OPC), .N_F(N_FN)) u_kind (
    .op_hit (op_hit),
    .fn_hit (fn_hit),
    .kind   (kind)
  );

  ctl_signal_gen u_gen (
    .kind (kind),
    .ctl  (ctl)
  );

  assign reg_dst_rd   = ctl.reg_dst_rd;
  assign mem_to_reg   = ctl.mem_to_reg;
  assign alu_op       = ctl.alu_op;
  assign mem_wr_en    = ctl.mem_wr_en;
  assign alu_src_imm  = ctl.alu_src_imm;
  assign reg_wr_en    = ctl.reg_wr_en;
  assign imm_sign_ext = ctl.imm_sign_ext;
  assign pc_jump      = ctl.pc_jump;
  assign pc_jump_reg  = ctl.pc_jump_reg;
  assign pc_branch_ne = ctl.pc_branch_ne;

endmodule

// File: rtl/ctl_decoder_unified_chk.sv
module ctl_decoder_unified_chk (
  input logic [5:0] instr_opcode,
  input logic [5:0] instr_funct,
  input logic       reg_dst_rd,
  input logic       mem_to_reg,
  input logic [1:0] alu_op,
  input logic       mem_wr_en,
  input logic       alu_src_imm,
  input logic       reg_wr_en,
  input logic       imm_sign_ext,
  input logic       pc_jump,
  input logic       pc_jump_reg,
  input logic       pc_branch_ne
);

  logic op_known, fn_known, quiet_case;

  always_comb begin
    op_known = (instr_opcode inside {6'b000000, 6'b100011, 6'b101011, 6'b000101,
                                     6'b001110, 6'b001000, 6'b000010});
    fn_known = (instr_funct inside {6'b001000, 6'b100000, 6'b100010, 6'b101010});
    quiet_case = !op_known || (instr_opcode == 6'b000000 && !fn_known);
  end

  always_comb begin
    if (!$isunknown({instr_opcode, instr_funct})) begin
      AST_ONE_REDIRECT: assert ($onehot0({pc_jump, pc_jump_reg, pc_branch_ne})); // R7
      AST_STORE_NO_WB: assert (!(mem_wr_en && reg_wr_en)); // R2
      AST_LOAD_PATH: assert (!mem_to_reg || (alu_src_imm && reg_wr_en)); // R3
      AST_RD_REGFORM: assert (!reg_dst_rd || (reg_wr_en && !alu_src_imm)); // R4
      AST_BRANCH_SUB: assert (!pc_branch_ne || alu_op == 2'b10); // R1
      AST_ZEXT_XOR: assert (imm_sign_ext || (alu_op == 2'b01 && alu_src_imm)); // R6
      AST_IMM_SRC: assert (!alu_src_imm || instr_opcode != 6'b000000); // R5
      AST_UNKNOWN_QUIET: assert (!quiet_case ||
        !(reg_wr_en || mem_wr_en || mem_to_reg || pc_jump || pc_jump_reg || pc_branch_ne)); // R8
    end
  end

endmodule

bind ctl_decoder_unified ctl_decoder_unified_chk u_chk (
  .instr_opcode (instr_opcode),
  .instr_funct  (instr_funct),
  .reg_dst_rd   (reg_dst_rd),
  .mem_to_reg   (mem_to_reg),
  .alu_op       (alu_op),
  .mem_wr_en    (mem_wr_en),
  .alu_src_imm  (alu_src_imm),
  .reg_wr_en    (reg_wr_en),
  .imm_sign_ext (imm_sign_ext),
  .pc_jump      (pc_jump),
  .pc_jump_reg  (pc_jump_reg),
  .pc_branch_ne (pc_branch_ne)
);

// File: tb/ctl_decoder_unified_tb.sv
`timescale 1ns/1ps
module ctl_decoder_unified_tb;

  typedef struct packed {
    logic       rd;
    logic       m2r;
    logic [1:0] aop;
    logic       mw;
    logic       src;
    logic       rw;
    logic       sx;
    logic       j;
    logic       jr;
    logic       br;
  } exp_t;

  typedef struct {
    exp_t  e;
    string tag;
    logic [5:0] op;
    logic [5:0] fn;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] instr_opcode = 6'd0;
  logic [5:0] instr_funct  = 6'd0;
  logic reg_dst_rd, mem_to_reg, mem_wr_en, alu_src_imm, reg_wr_en;
  logic imm_sign_ext, pc_jump, pc_jump_reg, pc_branch_ne;
  logic [1:0] alu_op;

  int n_cmp = 0;
  int n_bad = 0;
  bit driver_done = 1'b0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  ctl_decoder_unified u_dut (
    .instr_opcode (instr_opcode),
    .instr_funct  (instr_funct),
    .reg_dst_rd   (reg_dst_rd),
    .mem_to_reg   (mem_to_reg),
    .alu_op       (alu_op),
    .mem_wr_en    (mem_wr_en),
    .alu_src_imm  (alu_src_imm),
    .reg_wr_en    (reg_wr_en),
    .imm_sign_ext (imm_sign_ext),
    .pc_jump      (pc_jump),
    .pc_jump_reg  (pc_jump_reg),
    .pc_branch_ne (pc_branch_ne)
  );

  // Expected controls written from the requirement text.
  function automatic exp_t model(input logic [5:0] op, input logic [5:0] fn);
    exp_t e;
    e = '0;
    e.sx = 1'b1;
    if (op == 6'b100011) begin e.m2r = 1; e.src = 1; e.rw = 1; end
    else if (op == 6'b101011) begin e.mw = 1; e.src = 1; end
    else if (op == 6'b000101) begin e.aop = 2'b10; e.br = 1; end
    else if (op == 6'b001110) begin e.aop = 2'b01; e.src = 1; e.rw = 1; e.sx = 0; end
    else if (op == 6'b001000) begin e.src = 1; e.rw = 1; end
    else if (op == 6'b000010) e.j = 1;
    else if (op == 6'b000000) begin
      if (fn == 6'b001000) e.jr = 1;
      else if (fn == 6'b100000) begin e.rd = 1; e.rw = 1; end
      else if (fn == 6'b100010) begin e.rd = 1; e.rw = 1; e.aop = 2'b10; end
      else if (fn == 6'b101010) begin e.rd = 1; e.rw = 1; e.aop = 2'b11; end
    end
    return e;
  endfunction

  task automatic drive(input logic [5:0] op, input logic [5:0] fn, input string tag);
    item_t it;
    @(posedge clk);
    instr_opcode = op;
    instr_funct  = fn;
    it.e = model(op, fn);
    it.tag = tag;
    it.op = op;
    it.fn = fn;
    sb_q.push_back(it);
  endtask

  function automatic void cmp(input string req, input string tag, input string fld,
                              input logic [5:0] op, input logic [5:0] fn,
                              input logic [1:0] got, input logic [1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s op=%b fn=%b actual=%b expected=%b",
               req, tag, fld, op, fn, got, exp);
    end
  endfunction

  // Monitor: samples half a cycle after the drive edge (R10: no clock in DUT).
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      cmp("R1", it.tag, "alu_op",       it.op, it.fn, alu_op,               it.e.aop);
      cmp("R2", it.tag, "mem_wr_en",    it.op, it.fn, {1'b0, mem_wr_en},    {1'b0, it.e.mw});
      cmp("R2", it.tag, "mem_to_reg",   it.op, it.fn, {1'b0, mem_to_reg},   {1'b0, it.e.m2r});
      cmp("R3", it.tag, "reg_wr_en",    it.op, it.fn, {1'b0, reg_wr_en},    {1'b0, it.e.rw});
      cmp("R4", it.tag, "reg_dst_rd",   it.op, it.fn, {1'b0, reg_dst_rd},   {1'b0, it.e.rd});
      cmp("R5", it.tag, "alu_src_imm",  it.op, it.fn, {1'b0, alu_src_imm},  {1'b0, it.e.src});
      cmp("R6", it.tag, "imm_sign_ext", it.op, it.fn, {1'b0, imm_sign_ext}, {1'b0, it.e.sx});
      cmp("R7", it.tag, "pc_jump",      it.op, it.fn, {1'b0, pc_jump},      {1'b0, it.e.j});
      cmp("R7", it.tag, "pc_jump_reg",  it.op, it.fn, {1'b0, pc_jump_reg},  {1'b0, it.e.jr});
      cmp("R7", it.tag, "pc_branch_ne", it.op, it.fn, {1'b0, pc_branch_ne}, {1'b0, it.e.br});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time encoding: all-zero word is a register form with unknown funct (R8)
    drive(6'b000000, 6'b000000, "R8 initial zero word");
    // each recognised encoding
    drive(6'b100011, 6'b000000, "R2 load");
    drive(6'b101011, 6'b111111, "R2 store");
    drive(6'b000101, 6'b010101, "R7 bne");
    drive(6'b001110, 6'b000000, "R6 xori");
    drive(6'b001000, 6'b100000, "R3 addi");
    drive(6'b000010, 6'b001000, "R7 jump");
    drive(6'b000000, 6'b001000, "R7 jreg");
    drive(6'b000000, 6'b100000, "R4 add");
    drive(6'b000000, 6'b100010, "R1 sub");
    drive(6'b000000, 6'b101010, "R1 slt");
    // history independence: same encoding after different predecessors (R10)
    drive(6'b001110, 6'b000000, "R10 after slt");
    drive(6'b000000, 6'b100000, "R10 add after xori");
    // every opcode, funct fixed (R8 for unknowns)
    for (int o = 0; o < 64; o++) drive(6'(o), 6'b100000, "R8 opcode sweep");
    // every funct under register form
    for (int f = 0; f < 64; f++) drive(6'b000000, 6'(f), "R8 funct sweep");
    // funct must not matter for non-zero recognised opcodes (R9)
    for (int f = 0; f < 64; f += 3) begin
      drive(6'b100011, 6'(f), "R9 load");
      drive(6'b001110, 6'(f), "R9 xori");
      drive(6'b000101, 6'(f), "R9 bne");
      drive(6'b000010, 6'(f), "R9 jump");
    end
    repeat (3) @(posedge clk);
    driver_done = 1'b1;
  end

  initial begin
    fork
      wait (driver_done && sb_q.size() == 0);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule